// File: doc/BRIEF.md
# Sequential Mantissa Divider

This block divides one normalized floating-point mantissa by another and produces the result exponent alongside. Each operand mantissa is `MANT_W` bits wide with its leading one in the top bit, so its value lies in [1.0, 2.0). The width counts the guard and round positions. A restoring shift-and-subtract recurrence produces one quotient bit per clock cycle, starting at the most significant bit.

The first trial subtraction also normalizes the result. If the dividend mantissa is not smaller than the divisor mantissa, that subtraction already gives the top quotient bit, which is one. If the dividend mantissa is smaller, the exponent is lowered by one and the next step works on twice the dividend, so the top quotient bit is again one. Once the last quotient position has been filled, any remainder left over becomes a sticky bit for a later rounding stage.

Special operand classes, signs, rounding and packing are handled elsewhere. Both operands are assumed normal and nonzero.

Top module: `mant_divider`

## Requirements
- R1: On `done`, `quotientExp` (signed, two's complement) equals `dividendExp − divisorExp` when the dividend mantissa X is at least the divisor mantissa Y, and `dividendExp − divisorExp − 1` when X < Y.
- R2: On `done`, `quotient` equals floor(X·2^(MANT_W−1) / Y) when X ≥ Y, and floor(X·2^MANT_W / Y) when X < Y.
- R3: On `done`, bit MANT_W−1 of `quotient` is one for every pair of normalized operands.
- R4: On `done`, `sticky` is one exactly when the remainder of the division in R2 is nonzero.
- R5: `start` is accepted on a rising edge while the unit is idle. `done` is high in the cycle after the (MANT_W−1)th following rising edge when X ≥ Y, and after the MANT_W-th following edge when X < Y. No early stop happens when the remainder becomes zero.
- R6: `done` stays high for exactly one cycle per accepted operation.
- R7: A `start` raised while an operation is in progress is ignored. The running operation finishes with its own operands and its own timing.
- R8: After `done`, `quotient`, `quotientExp` and `sticky` keep their values until the next accepted `start`.
- R9: During and right after reset, `done`, `quotient`, `quotientExp` and `sticky` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division with the operands present on this edge |
| dividend | input | MANT_W | Dividend mantissa X, leading one in the top bit |
| divisor | input | MANT_W | Divisor mantissa Y, leading one in the top bit |
| dividendExp | input | EXP_W | Dividend exponent, signed |
| divisorExp | input | EXP_W | Divisor exponent, signed |
| quotient | output | MANT_W | Normalized quotient mantissa |
| quotientExp | output | EXP_W+1 | Result exponent, signed |
| sticky | output | 1 | One when the final remainder is nonzero |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
The hardest cases to reach are the two boundary orderings: X exactly equal to Y, and X just one unit below Y. These decide whether the exponent drops and whether the operation takes one extra cycle. The stimulus drives both directly, together with the extreme mantissa pairs and a large random set, so that both latencies and both exponent branches occur many times. A second start is placed in the middle of a running division, and a new start is raised in the same cycle that `done` is seen. These show that the busy window neither drops nor duplicates an operation.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands and perform the first trial subtraction
    logic step;  // one shift-and-subtract iteration
    logic last;  // this iteration fills the least significant quotient bit
  } mdiv_ctl_t;
endpackage

// File: rtl/mdiv_ctrl.sv
module mdiv_ctrl
  import mdiv_pkg::*;
#(
  parameter int MANT_W = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      firstNeg,
  output mdiv_ctl_t ctl,
  output logic      busy,
  output logic      done
);
  localparam int CNT_W = $clog2(MANT_W + 1);

  logic [CNT_W-1:0] bitsLeft;

  always_comb begin
    ctl.load = start && !busy;
    ctl.step = busy;
    ctl.last = busy && (bitsLeft == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      bitsLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= ctl.last;
      if (ctl.load) begin
        busy     <= 1'b1;
        // one extra iteration when the first subtraction yields no bit
        bitsLeft <= firstNeg ? CNT_W'(MANT_W) : CNT_W'(MANT_W - 1);
      end else if (ctl.step) begin
        bitsLeft <= bitsLeft - CNT_W'(1);
        if (ctl.last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdiv_dpath.sv
module mdiv_dpath
  import mdiv_pkg::*;
#(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdiv_ctl_t         ctl,
  input  logic [MANT_W-1:0] dividend,
  input  logic [MANT_W-1:0] divisor,
  input  logic [EXP_W-1:0]  dividendExp,
  input  logic [EXP_W-1:0]  divisorExp,
  output logic              firstNeg,
  output logic [MANT_W-1:0] quotient,
  output logic [EXP_W:0]    quotientExp,
  output logic              sticky
);
  localparam int REM_W = MANT_W + 1;  // holds a shifted remainder below 2Y
  localparam int DIF_W = MANT_W + 2;  // one more for the borrow

  logic [MANT_W-1:0] divReg;
  logic [REM_W-1:0]  rem, remShift, remNext;
  logic [DIF_W-1:0]  initDiff, trial;
  logic              bitOk;
  logic [EXP_W:0]    expA, expB;

  always_comb begin
    initDiff = {2'b00, dividend} - {2'b00, divisor};
    firstNeg = initDiff[DIF_W-1];
    remShift = {rem[REM_W-2:0], 1'b0};
    trial    = {1'b0, remShift} - {2'b00, divReg};
    bitOk    = !trial[DIF_W-1];
    remNext  = bitOk ? trial[REM_W-1:0] : remShift;
    expA     = {dividendExp[EXP_W-1], dividendExp};
    expB     = {divisorExp[EXP_W-1], divisorExp};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg      <= '0;
      rem         <= '0;
      quotient    <= '0;
      quotientExp <= '0;
      sticky      <= 1'b0;
    end else if (ctl.load) begin
      divReg      <= divisor;
      rem         <= firstNeg ? {1'b0, dividend} : initDiff[REM_W-1:0];
      quotient    <= {{(MANT_W-1){1'b0}}, !firstNeg};
      quotientExp <= expA - expB - {{EXP_W{1'b0}}, firstNeg};
      sticky      <= 1'b0;
    end else if (ctl.step) begin
      rem      <= remNext;
      quotient <= {quotient[MANT_W-2:0], bitOk};
      if (ctl.last) sticky <= |remNext;
    end
  end
endmodule

// File: rtl/mant_divider.sv
module mant_divider
  import mdiv_pkg::*;
#(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MANT_W-1:0] dividend,
  input  logic [MANT_W-1:0] divisor,
  input  logic [EXP_W-1:0]  dividendExp,
  input  logic [EXP_W-1:0]  divisorExp,
  output logic [MANT_W-1:0] quotient,
  output logic [EXP_W:0]    quotientExp,
  output logic              sticky,
  output logic              done
);
  mdiv_ctl_t ctl;
  logic      firstNeg;
  logic      busy;

  mdiv_ctrl #(.MANT_W(MANT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .firstNeg(firstNeg),
    .ctl(ctl), .busy(busy), .done(done)
  );

  mdiv_dpath #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .dividend(dividend), .divisor(divisor),
    .dividendExp(dividendExp), .divisorExp(divisorExp),
    .firstNeg(firstNeg), .quotient(quotient),
    .quotientExp(quotientExp), .sticky(sticky)
  );
endmodule

// File: rtl/mant_divider_chk.sv
module mant_divider_chk #(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [MANT_W-1:0] quotient,
  input logic [EXP_W:0]    quotientExp,
  input logic              sticky
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> quotient[MANT_W-1]); // R3
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(quotient) && $stable(quotientExp) && $stable(sticky))); // R8
  AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done) |=> (busy || done)); // R7
endmodule

bind mant_divider mant_divider_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .quotientExp(quotientExp), .sticky(sticky)
);

// File: tb/mant_divider_bench.sv
module mant_divider_bench;
  localparam int MANT_W = 12;
  localparam int EXP_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [MANT_W-1:0] dividend = '0, divisor = '0;
  logic [EXP_W-1:0]  dividendExp = '0, divisorExp = '0;
  logic [MANT_W-1:0] quotient;
  logic [EXP_W:0]    quotientExp;
  logic              sticky, done;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  mant_divider #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_mant_divider (
    .clk(clk), .rstN(rstN), .start(start),
    .dividend(dividend), .divisor(divisor),
    .dividendExp(dividendExp), .divisorExp(divisorExp),
    .quotient(quotient), .quotientExp(quotientExp),
    .sticky(sticky), .done(done)
  );

  // behavioural reference, advanced on each rising edge
  bit    mBusy = 0, mDone = 0, mValid = 0;
  int    mLeft = 0;
  longint mQuot = 0;
  int    mExp = 0;
  bit    mSticky = 0;

  always @(posedge clk) begin
    mDone = 0;
    if (!rstN) begin
      mBusy = 0; mValid = 0; mLeft = 0;
      mQuot = 0; mExp = 0; mSticky = 0;
    end else if (!mBusy && start) begin
      longint num;
      int k;
      k = (dividend < divisor) ? MANT_W : MANT_W - 1;
      num = longint'(dividend) << k;
      mQuot   = num / longint'(divisor);
      mSticky = (num % longint'(divisor)) != 0;
      mExp    = int'($signed(dividendExp)) - int'($signed(divisorExp))
                - ((dividend < divisor) ? 1 : 0);
      mLeft   = k;
      mBusy   = 1;
      mValid  = 0;
    end else if (mBusy) begin
      mLeft = mLeft - 1;
      if (mLeft == 0) begin
        mBusy = 0; mDone = 1; mValid = 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN) begin
      check(done == mDone, "R5 done timing", done, mDone);
      if (mValid && !mBusy) begin
        check(longint'(quotient) == mQuot, "R2 quotient", quotient, mQuot);
        check(int'($signed(quotientExp)) == mExp, "R1 exponent",
              int'($signed(quotientExp)), mExp);
        check(sticky == mSticky, "R4 sticky", sticky, mSticky);
        if (mDone) check(quotient[MANT_W-1] == 1'b1, "R3 leading one", quotient[MANT_W-1], 1);
      end
    end
  end

  task automatic issue(input logic [MANT_W-1:0] a, input logic [MANT_W-1:0] b,
                       input int ea, input int eb);
    @(negedge clk);
    dividend = a; divisor = b;
    dividendExp = EXP_W'(ea); divisorExp = EXP_W'(eb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runOp(input logic [MANT_W-1:0] a, input logic [MANT_W-1:0] b,
                       input int ea, input int eb);
    issue(a, b, ea, eb);
    repeat (MANT_W + 2) @(negedge clk);
  endtask

  function automatic logic [MANT_W-1:0] rndMant();
    logic [MANT_W-1:0] m;
    m = MANT_W'($urandom);
    m[MANT_W-1] = 1'b1;
    return m;
  endfunction

  localparam logic [MANT_W-1:0] ONE  = {1'b1, {(MANT_W-1){1'b0}}};
  localparam logic [MANT_W-1:0] MAXM = '1;

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9 reset done", done, 0);
    check(quotient == '0, "R9 reset quotient", quotient, 0);
    check(quotientExp == '0, "R9 reset exponent", quotientExp, 0);
    check(sticky == 1'b0, "R9 reset sticky", sticky, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && quotient == '0, "R9 after reset", quotient, 0);

    // boundary orderings and extremes (R1 R2 R4 R5)
    runOp(ONE, ONE, 3, 3);
    runOp(MAXM, MAXM, -5, 7);
    runOp(ONE, ONE + 1, 10, -10);
    runOp(MAXM - 1, MAXM, 0, 0);
    runOp(MAXM, ONE, 127, -128);
    runOp(ONE, MAXM, -128, 127);
    runOp(ONE | (ONE >> 1), ONE, 1, 2);
    runOp(ONE, ONE | (ONE >> 1), 1, 2);

    // R7: second start while busy is ignored
    begin
      longint expQ;
      longint num;
      num  = longint'(MAXM) << (MANT_W - 1);
      expQ = num / longint'(ONE | 12'h155);
      issue(MAXM, ONE | 12'h155, 4, 1);
      repeat (3) @(negedge clk);
      issue(ONE, MAXM, 9, 9);
      repeat (MANT_W) @(negedge clk);
      check(longint'(quotient) == expQ, "R7 ignored start", quotient, expQ);
      check(int'($signed(quotientExp)) == 3, "R7 ignored start exp",
            int'($signed(quotientExp)), 3);
    end

    // R8: hold several idle cycles, then back-to-back start on done
    repeat (6) @(negedge clk);
    issue(ONE + 7, MAXM - 3, 2, -1);
    while (!done) @(negedge clk);
    dividend = MAXM - 9; divisor = ONE + 33;
    dividendExp = 8'd5; divisorExp = 8'd6;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (MANT_W + 2) @(negedge clk);

    // random operands
    for (int i = 0; i < 300; i++) begin
      runOp(rndMant(), rndMant(), int'($urandom_range(0, 255)) - 128,
            int'($urandom_range(0, 255)) - 128);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule